// File: doc/BRIEF.md
# Dual-Bank Event Interrupt Controller

This block collects single-cycle event pulses from six transfer channels and turns them into one level-sensitive interrupt line. Events are sorted into two independent banks: a normal bank (completions, payload read failures and a frame-sync event) and an error bank (descriptor fetch failures, bad preambles, checksum mismatches and stale descriptors). Each bank keeps a sticky 32-bit status word and a 32-bit mask word.

Software sees eight word registers on a simple single-cycle bus with a combinational read path. Status bits are cleared by writing ones. The mask cannot be written directly: it changes only through a dedicated unmask port (ones clear mask bits) and a dedicated mask port (ones set mask bits), so no read-modify-write sequence is needed. The interrupt output is a registered OR of the unmasked status of both banks.

Top module: `evt_irq_banks`

## Requirements
- R1: After reset both status words read 0, the normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF and irq is 0.
- R2: A bus write to a status word (word address 0 for normal, 4 for error) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R3: A bus write to an unmask port (word address 2 for normal, 6 for error) clears the mask bits written as 1 in that bank and leaves the others.
- R4: A bus write to a mask port (word address 3 for normal, 7 for error) sets the mask bits written as 1 in that bank and leaves the others.
- R5: A bus write to a mask word (word address 1 for normal, 5 for error) changes neither mask nor status.
- R6: Reads of word addresses 2, 3, 6 and 7 return 0; reads of 0, 1, 4, 5 return the normal status, normal mask, error status and error mask.
- R7: irq equals, one clock after any state, the OR over both banks of (status AND NOT mask).
- R8: In the normal bank a completion pulse on channel n sets bit n, a payload read failure on channel n sets bit 12+n, and the frame-sync pulse sets bit 27.
- R9: In the error bank channel n sets bit 1+n on a fetch failure, 7+n on a bad preamble, 13+n on a checksum mismatch and 25+n on a stale descriptor.
- R10: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends set.
- R11: A status bit stays set after its event pulse ends until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| desc_done | input | 6 | Per-channel completion pulses |
| payload_err | input | 6 | Per-channel payload read failure pulses |
| vsync_evt | input | 1 | Frame-sync pulse |
| fetch_err | input | 6 | Per-channel descriptor fetch failure pulses |
| preamble_err | input | 6 | Per-channel bad preamble pulses |
| csum_err | input | 6 | Per-channel checksum mismatch pulses |
| stale_err | input | 6 | Per-channel already-processed descriptor pulses |
| irq | output | 1 | Registered interrupt level |

## Verification
The bench aims at the same-cycle collision of an event and a clear, where a design giving the clear priority would silently lose an event and never raise irq. It writes the mask word directly with patterns that differ from its contents, which a design decoding that address as writable would expose through a changed mask readback. It checks that the frame-sync bit is unmasked from reset, so a wrong reset mask shows as a missing interrupt, and it samples irq exactly one edge after each state change so an unregistered or twice-registered output is caught. Random traffic mixes sparse events with all eight register addresses to catch any misplaced bit in the channel maps.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_CH = 6;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_NSTAT = 3'd0,
    SEL_NMASK = 3'd1,
    SEL_NUNM  = 3'd2,
    SEL_NMSK  = 3'd3,
    SEL_ESTAT = 3'd4,
    SEL_EMASK = 3'd5,
    SEL_EUNM  = 3'd6,
    SEL_EMSK  = 3'd7
  } reg_sel_e;

  // Bit positions decoded by software; they must not move.
  localparam int unsigned NB_DONE     = 0;
  localparam int unsigned NB_PAYLOAD  = 12;
  localparam int unsigned NB_VSYNC    = 27;
  localparam int unsigned EB_FETCH    = 1;
  localparam int unsigned EB_PREAMBLE = 7;
  localparam int unsigned EB_CSUM     = 13;
  localparam int unsigned EB_STALE    = 25;

  localparam logic [DATA_W-1:0] NORM_MASK_RST = 32'h07FF_FFFF;
  localparam logic [DATA_W-1:0] ERR_MASK_RST  = 32'hFFFF_FFFF;
endpackage

// File: rtl/irqb_event_map.sv
module irqb_event_map
  import irqb_pkg::*;
(
  input  logic [NUM_CH-1:0] desc_done,
  input  logic [NUM_CH-1:0] payload_err,
  input  logic              vsync_evt,
  input  logic [NUM_CH-1:0] fetch_err,
  input  logic [NUM_CH-1:0] preamble_err,
  input  logic [NUM_CH-1:0] csum_err,
  input  logic [NUM_CH-1:0] stale_err,
  output logic [DATA_W-1:0] set_norm,
  output logic [DATA_W-1:0] set_err
);
  logic [NUM_CH-1:0][DATA_W-1:0] norm_part;
  logic [NUM_CH-1:0][DATA_W-1:0] err_part;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      norm_part[ch] = '0;
      norm_part[ch][NB_DONE + ch]    = desc_done[ch];
      norm_part[ch][NB_PAYLOAD + ch] = payload_err[ch];
      err_part[ch] = '0;
      err_part[ch][EB_FETCH + ch]    = fetch_err[ch];
      err_part[ch][EB_PREAMBLE + ch] = preamble_err[ch];
      err_part[ch][EB_CSUM + ch]     = csum_err[ch];
      err_part[ch][EB_STALE + ch]    = stale_err[ch];
    end
  end

  always_comb begin
    set_norm = '0;
    set_err  = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      set_norm = set_norm | norm_part[ch];
      set_err  = set_err  | err_part[ch];
    end
    set_norm[NB_VSYNC] = set_norm[NB_VSYNC] | vsync_evt;
  end
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank #(
  parameter int unsigned       W        = 32,
  parameter logic [W-1:0]      RST_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic         unmask_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] mask_q, mask_d;
  logic         status_ce, mask_ce;

  always_comb begin
    status_d = status_q;
    if (clr_we) status_d = status_d & ~wdata;
    status_d  = status_d | set_i;            // set has priority over clear
    status_ce = clr_we | (|set_i);
  end

  always_comb begin
    mask_d = mask_q;
    if (unmask_we)    mask_d = mask_q & ~wdata;
    else if (mask_we) mask_d = mask_q | wdata;
    mask_ce = unmask_we | mask_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_ce) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_MASK;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign pend_o   = |(status_q & ~mask_q);
endmodule

// File: rtl/evt_irq_banks.sv
module evt_irq_banks
  import irqb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] desc_done,
  input  logic [NUM_CH-1:0] payload_err,
  input  logic              vsync_evt,
  input  logic [NUM_CH-1:0] fetch_err,
  input  logic [NUM_CH-1:0] preamble_err,
  input  logic [NUM_CH-1:0] csum_err,
  input  logic [NUM_CH-1:0] stale_err,
  output logic              irq
);
  logic [DATA_W-1:0] set_norm, set_err;
  logic [DATA_W-1:0] norm_status, norm_mask, err_status, err_mask;
  logic              norm_pend, err_pend;
  logic              irq_q, irq_d;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(bus_addr);

  irqb_event_map u_map (
    .desc_done    (desc_done),
    .payload_err  (payload_err),
    .vsync_evt    (vsync_evt),
    .fetch_err    (fetch_err),
    .preamble_err (preamble_err),
    .csum_err     (csum_err),
    .stale_err    (stale_err),
    .set_norm     (set_norm),
    .set_err      (set_err)
  );

  irqb_bank #(.W(DATA_W), .RST_MASK(NORM_MASK_RST)) u_norm (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_norm),
    .clr_we    (bus_we && sel == SEL_NSTAT),
    .unmask_we (bus_we && sel == SEL_NUNM),
    .mask_we   (bus_we && sel == SEL_NMSK),
    .wdata     (bus_wdata),
    .status_o  (norm_status),
    .mask_o    (norm_mask),
    .pend_o    (norm_pend)
  );

  irqb_bank #(.W(DATA_W), .RST_MASK(ERR_MASK_RST)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_err),
    .clr_we    (bus_we && sel == SEL_ESTAT),
    .unmask_we (bus_we && sel == SEL_EUNM),
    .mask_we   (bus_we && sel == SEL_EMSK),
    .wdata     (bus_wdata),
    .status_o  (err_status),
    .mask_o    (err_mask),
    .pend_o    (err_pend)
  );

  always_comb begin
    unique case (sel)
      SEL_NSTAT: bus_rdata = norm_status;
      SEL_NMASK: bus_rdata = norm_mask;
      SEL_ESTAT: bus_rdata = err_status;
      SEL_EMASK: bus_rdata = err_mask;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_d = norm_pend | err_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker
  import irqb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] set_norm,
  input logic [DATA_W-1:0] set_err,
  input logic [DATA_W-1:0] norm_status,
  input logic [DATA_W-1:0] norm_mask,
  input logic [DATA_W-1:0] err_status,
  input logic [DATA_W-1:0] err_mask,
  input logic              irq
);
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(|(norm_status & ~norm_mask)) || $past(|(err_status & ~err_mask))));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_norm) |=> ((norm_status & $past(set_norm)) == $past(set_norm)));

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_err) |=> ((err_status & $past(set_err)) == $past(set_err)));

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && set_norm == '0) |=> ((norm_status & $past(bus_wdata)) == '0));

  p_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd6) |=> ((err_mask & $past(bus_wdata)) == '0));

  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3) |=> ((norm_mask & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 3'd1 || bus_addr == 3'd5)) |=> ($stable(norm_mask) && $stable(err_mask)));

  p_port_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1]) |-> bus_rdata == '0);
endmodule

bind evt_irq_banks irqb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .set_norm    (set_norm),
  .set_err     (set_err),
  .norm_status (norm_status),
  .norm_mask   (norm_mask),
  .err_status  (err_status),
  .err_mask    (err_mask),
  .irq         (irq)
);

// File: tb/sim_evt_irq_banks.sv
`timescale 1ns/1ps
module sim_evt_irq_banks;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  desc_done = '0, payload_err = '0, fetch_err = '0;
  logic [5:0]  preamble_err = '0, csum_err = '0, stale_err = '0;
  logic        vsync_evt = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] last_rd;
  logic [31:0] m_sn, m_mn, m_se, m_me;

  always #2.5 clk = ~clk;

  evt_irq_banks u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .desc_done(desc_done),
    .payload_err(payload_err), .vsync_evt(vsync_evt), .fetch_err(fetch_err),
    .preamble_err(preamble_err), .csum_err(csum_err), .stale_err(stale_err),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R8 bit map
  function automatic logic [31:0] nset(input logic [5:0] dn, input logic [5:0] pf, input logic vs);
    logic [31:0] v = '0;
    for (int c = 0; c < 6; c++) begin
      v[c] = dn[c];
      v[12 + c] = pf[c];
    end
    v[27] = vs;
    return v;
  endfunction

  // R9 bit map
  function automatic logic [31:0] eset(input logic [5:0] ff, input logic [5:0] pb,
                                       input logic [5:0] cs, input logic [5:0] st);
    logic [31:0] v = '0;
    for (int c = 0; c < 6; c++) begin
      v[1 + c]  = ff[c];
      v[7 + c]  = pb[c];
      v[13 + c] = cs[c];
      v[25 + c] = st[c];
    end
    return v;
  endfunction

  function automatic logic [31:0] mrd(input logic [2:0] a);
    case (a)
      3'd0: return m_sn;
      3'd1: return m_mn;
      3'd4: return m_se;
      3'd5: return m_me;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd4: return "R2";
      3'd1, 3'd5: return "R5";
      default:    return "R6";
    endcase
  endfunction

  // One clock: drive at negedge, check read, predict, check irq at next negedge.
  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                      input logic [5:0] dn, input logic [5:0] pf, input logic vs,
                      input logic [5:0] ff, input logic [5:0] pb,
                      input logic [5:0] cs, input logic [5:0] st);
    logic pend;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    desc_done = dn; payload_err = pf; vsync_evt = vs;
    fetch_err = ff; preamble_err = pb; csum_err = cs; stale_err = st;
    #1;
    last_rd = bus_rdata;
    chk(tag_of(a), bus_rdata, mrd(a));
    pend = |(m_sn & ~m_mn) || |(m_se & ~m_me);
    if (we && a == 3'd0) m_sn = m_sn & ~wd;
    if (we && a == 3'd4) m_se = m_se & ~wd;
    m_sn = m_sn | nset(dn, pf, vs);
    m_se = m_se | eset(ff, pb, cs, st);
    if (we && a == 3'd2) m_mn = m_mn & ~wd;
    if (we && a == 3'd3) m_mn = m_mn | wd;
    if (we && a == 3'd6) m_me = m_me & ~wd;
    if (we && a == 3'd7) m_me = m_me | wd;
    @(negedge clk);
    chk("R7", {31'b0, irq}, {31'b0, pend});
  endtask

  task automatic idle(input logic [2:0] a);
    step(1'b0, a, 32'h0, 6'h0, 6'h0, 1'b0, 6'h0, 6'h0, 6'h0, 6'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, 6'h0, 6'h0, 1'b0, 6'h0, 6'h0, 6'h0, 6'h0);
  endtask

  bit done_flag = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_sn = 32'h0; m_mn = 32'h07FF_FFFF; m_se = 32'h0; m_me = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", {31'b0, irq}, 32'h0);
    idle(3'd0); chk("R1", last_rd, 32'h0);
    idle(3'd1); chk("R1", last_rd, 32'h07FF_FFFF);
    idle(3'd4); chk("R1", last_rd, 32'h0);
    idle(3'd5); chk("R1", last_rd, 32'hFFFF_FFFF);

    // R8 frame-sync is unmasked from reset
    step(1'b0, 3'd0, 0, 6'h0, 6'h0, 1'b1, 6'h0, 6'h0, 6'h0, 6'h0);
    idle(3'd0); chk("R8", last_rd, 32'h0800_0000);
    chk("R8", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0800_0000);
    idle(3'd0); chk("R2", last_rd, 32'h0);
    chk("R2", {31'b0, irq}, 32'h0);

    // completion ch3 masked, then unmask / mask
    step(1'b0, 3'd0, 0, 6'h08, 6'h20, 1'b0, 6'h0, 6'h0, 6'h0, 6'h0);
    idle(3'd0); chk("R8", last_rd, 32'h0002_0008);
    chk("R11", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h0000_0008);
    idle(3'd1); chk("R3", last_rd, 32'h07FF_FFF7);
    chk("R7", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h0000_0008);
    idle(3'd1); chk("R4", last_rd, 32'h07FF_FFFF);

    // R10 set beats clear in the same cycle
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 6'h08, 6'h0, 1'b0, 6'h0, 6'h0, 6'h0, 6'h0);
    idle(3'd0); chk("R10", last_rd, 32'h0000_0008);
    wr(3'd0, 32'h0000_0008);

    // R5 direct mask writes ignored
    wr(3'd1, 32'h1234_5678);
    wr(3'd5, 32'h0);
    idle(3'd1); chk("R5", last_rd, 32'h07FF_FFFF);
    idle(3'd5); chk("R5", last_rd, 32'hFFFF_FFFF);

    // R9 error bank map, R11 sticky
    step(1'b0, 3'd4, 0, 6'h0, 6'h0, 1'b0, 6'h01, 6'h20, 6'h02, 6'h08);
    idle(3'd4); chk("R9", last_rd, 32'h1000_5002);
    idle(3'd4); chk("R11", last_rd, 32'h1000_5002);
    chk("R9", {31'b0, irq}, 32'h0);
    wr(3'd6, 32'h0000_4000);
    idle(3'd5); chk("R3", last_rd, 32'hFFFF_BFFF);
    chk("R7", {31'b0, irq}, 32'h1);

    // R6 port reads
    wr(3'd2, 32'hFFFF_FFFF); chk("R6", last_rd, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF); chk("R6", last_rd, 32'h0);
    idle(3'd3); chk("R6", last_rd, 32'h0);
    idle(3'd6); chk("R6", last_rd, 32'h0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      wd = ($urandom % 6 == 0) ? 32'hFFFF_FFFF : $urandom;
      step(($urandom % 3) == 0, 3'($urandom % 8), wd,
           6'($urandom & $urandom & $urandom), 6'($urandom & $urandom & $urandom),
           ($urandom % 8) == 0,
           6'($urandom & $urandom & $urandom), 6'($urandom & $urandom & $urandom),
           6'($urandom & $urandom & $urandom), 6'($urandom & $urandom & $urandom));
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule